// File: doc/BRIEF.md
# Chain Descriptor Loader

This block refills one DMA channel's register set from a linked descriptor held in word-wide memory. A start pulse hands it the channel's chain address as a 16-bit upper word (address bits 23:16 in bits 15:8, control bits in 7:0) and a 16-bit lower word. The block first reads a reload word from that address. The reload word's flag bits select which register groups follow. The block then reads only the selected groups, always in the same order, and stores each group through a single registered write port that the channel's register file decodes.

Each group is one or two consecutive 16-bit words. When the descriptor does not carry a new chain address, the block writes the address just past the last word it read as the next chain address. When loading ends it pulses `done`. The channel clears its chain-abort and no-auto-reload status bits on that pulse. The block also pulses `sr_go` to launch a transfer when the channel's mode, new or kept, has its software-request bit set. Bus arbitration and abort on end-of-process are handled elsewhere.

Top module: `chain_loader`

## Requirements
- R1: A `start` pulse while `busy` is low raises `busy` in the next cycle and makes the first memory read at {`ca_hi`[15:8], `ca_lo`}. A `start` while `busy` is high is ignored.
- R2: Reload word bit 9 selects current address A (field code 0), bit 8 current address B (1), bit 7 current count (2), bit 6 base address A (3), bit 5 base address B (4), bit 4 base count (5), bit 3 pattern and mask (6), bit 2 vector (7), bit 1 mode (8) and bit 0 chain address (9). Bits 15:10 are ignored. Selected fields are written in ascending field code order, one `wr_en` pulse each.
- R3: Each memory read is at the previous read address plus 2, modulo 2^24. Codes 2, 5 and 7 read one word. Every other field reads two words, upper word first. No other reads occur.
- R4: One-word fields appear on `wr_lo` with `wr_hi` = 0. For two-word fields `wr_lo` is the second word and `wr_hi` is the first word ANDed with a mask. The mask is 16'hFFFE for codes 0, 1, 3 and 4, 16'hFFFF for code 6, 16'h001F for code 8 and 16'hFF06 for code 9.
- R5: When reload bit 0 is clear, the final write is code 9 with `wr_lo` = bits 15:0 and `wr_hi` = {bits 23:16, `ca_hi`[7:0] from the start}, where the address is the last read address plus 2.
- R6: `done` is high for exactly one cycle per load, at or after the final write. `busy` is low while `done` is high, and no write follows `done` before the next start.
- R7: `sr_go` pulses together with `done` exactly when the software-request bit is set. That bit is bit 4 of the loaded mode upper word if code 8 was loaded, and otherwise the `cur_sr` input.
- R8: `mem_req` stays high with a stable `mem_addr` until `mem_ack`, which completes one word. A `mem_ack` while `mem_req` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a load (start-chain command or chaining completion) |
| ca_hi | input | 16 | Current chain address upper word |
| ca_lo | input | 16 | Current chain address lower word |
| cur_sr | input | 1 | Channel's present software-request bit |
| busy | output | 1 | Load in progress |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 24 | Byte address of the word read |
| mem_ack | input | 1 | Read completion |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| wr_en | output | 1 | Register group write strobe |
| wr_field | output | 4 | Field code of the write (see R2) |
| wr_hi | output | 16 | Upper word, masked |
| wr_lo | output | 16 | Lower word, or the single word |
| done | output | 1 | Load finished pulse |
| sr_go | output | 1 | Start a transfer after chaining |

## Verification
The hardest case to reach is the full product of flag combinations with address behaviour at its edges. That means descriptors whose pointer crosses a 64 KiB boundary, so the fallback chain address picks up a new upper byte, and descriptors that wrap past the top of the 24-bit space. The bench sweeps all 1024 reload-word flag patterns with junk in the ignored bits. It rotates the start address through wrap-around, boundary-crossing and plain placements, varies the acknowledge latency from zero to two cycles, and injects a second `start` in the middle of some loads. Every read address, write and pulse is predicted from a memory image that the bench computes arithmetically.

// File: rtl/chain_ldr_pkg.sv
package chain_ldr_pkg;
  localparam int NFIELD = 10;
  localparam int FW     = 4;

  typedef enum logic [FW-1:0] {
    FLD_CUR_A    = 4'd0,
    FLD_CUR_B    = 4'd1,
    FLD_CUR_CNT  = 4'd2,
    FLD_BASE_A   = 4'd3,
    FLD_BASE_B   = 4'd4,
    FLD_BASE_CNT = 4'd5,
    FLD_PAT_MASK = 4'd6,
    FLD_VECTOR   = 4'd7,
    FLD_MODE     = 4'd8,
    FLD_CHAIN    = 4'd9
  } field_e;

  function automatic logic is_single(field_e f);
    return (f == FLD_CUR_CNT) || (f == FLD_BASE_CNT) || (f == FLD_VECTOR);
  endfunction
endpackage

// File: rtl/chain_ldr_pick.sv
module chain_ldr_pick #(
  parameter int N  = 10,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  pend,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/chain_ldr_fetch.sv
module chain_ldr_fetch #(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [AW-1:0] go_addr,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          word_vld,
  output logic [DW-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req  <= 1'b0;
      mem_addr <= '0;
      word_vld <= 1'b0;
      word     <= '0;
    end else begin
      word_vld <= 1'b0;
      if (mem_req && mem_ack) begin
        mem_req  <= 1'b0;
        word     <= mem_rdata;
        word_vld <= 1'b1;
      end else if (go && !mem_req) begin
        mem_req  <= 1'b1;
        mem_addr <= go_addr;
      end
    end
  end

  // R8: request held, address steady until acknowledged
  p_req_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R8: a completion only follows an outstanding request
  p_vld_after_req_r8: assert property (@(posedge clk) disable iff (rst)
    word_vld |-> ($past(mem_req) && $past(mem_ack)));
endmodule

// File: rtl/chain_loader.sv
module chain_loader
  import chain_ldr_pkg::*;
#(
  parameter int          AW            = 24,
  parameter int          DW            = 16,
  parameter logic [15:0] ADDR_HI_MASK  = 16'hFFFE,
  parameter logic [15:0] MODE_HI_MASK  = 16'h001F,
  parameter logic [15:0] CHAIN_HI_MASK = 16'hFF06,
  parameter int          SR_BIT        = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] ca_hi,
  input  logic [DW-1:0] ca_lo,
  input  logic          cur_sr,
  output logic          busy,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          wr_en,
  output logic [FW-1:0] wr_field,
  output logic [DW-1:0] wr_hi,
  output logic [DW-1:0] wr_lo,
  output logic          done,
  output logic          sr_go
);
  localparam int UPW = AW - DW;
  localparam int CTW = DW - UPW;
  localparam int IW  = $clog2(NFIELD);

  typedef enum logic [2:0] {ST_IDLE, ST_HDR, ST_PICK, ST_W0, ST_W1, ST_FIN} st_e;

  st_e               st;
  logic [AW-1:0]     ptr;
  logic [CTW-1:0]    ctl;
  logic [NFIELD-1:0] pend;
  field_e            cur;
  logic [DW-1:0]     hi_q;
  logic              ca_loaded, cm_loaded, cm_sr;

  logic              go, word_vld, any;
  logic [AW-1:0]     go_addr;
  logic [DW-1:0]     word;
  logic [IW-1:0]     idx;
  logic [NFIELD-1:0] hdr_flags;
  logic [DW-1:0]     hi_masked;

  // reload bit (NFIELD-1-f) selects field f
  for (genvar f = 0; f < NFIELD; f++) begin : g_flag
    assign hdr_flags[f] = word[NFIELD-1-f];
  end

  always_comb begin
    unique case (cur)
      FLD_CUR_A, FLD_CUR_B, FLD_BASE_A, FLD_BASE_B: hi_masked = hi_q & ADDR_HI_MASK;
      FLD_MODE:  hi_masked = hi_q & MODE_HI_MASK;
      FLD_CHAIN: hi_masked = hi_q & CHAIN_HI_MASK;
      default:   hi_masked = hi_q;
    endcase
  end

  always_comb begin
    go      = 1'b0;
    go_addr = ptr;
    case (st)
      ST_IDLE: begin
        go      = start;
        go_addr = {ca_hi[DW-1 -: UPW], ca_lo};
      end
      ST_PICK: go = any;
      ST_W0: begin
        go      = word_vld && !is_single(cur);
        go_addr = ptr + AW'(2);
      end
      default: ;
    endcase
  end

  chain_ldr_pick #(.N(NFIELD)) u_pick (
    .pend (pend),
    .any  (any),
    .idx  (idx)
  );

  chain_ldr_fetch #(.AW(AW), .DW(DW)) u_fetch (
    .clk       (clk),
    .rst       (rst),
    .go        (go),
    .go_addr   (go_addr),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .word_vld  (word_vld),
    .word      (word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      ptr       <= '0;
      ctl       <= '0;
      pend      <= '0;
      cur       <= FLD_CUR_A;
      hi_q      <= '0;
      ca_loaded <= 1'b0;
      cm_loaded <= 1'b0;
      cm_sr     <= 1'b0;
      busy      <= 1'b0;
      wr_en     <= 1'b0;
      wr_field  <= '0;
      wr_hi     <= '0;
      wr_lo     <= '0;
      done      <= 1'b0;
      sr_go     <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      done  <= 1'b0;
      sr_go <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          ptr       <= {ca_hi[DW-1 -: UPW], ca_lo};
          ctl       <= ca_hi[CTW-1:0];
          ca_loaded <= 1'b0;
          cm_loaded <= 1'b0;
          busy      <= 1'b1;
          st        <= ST_HDR;
        end
        ST_HDR: if (word_vld) begin
          ptr  <= ptr + AW'(2);
          pend <= hdr_flags;
          st   <= ST_PICK;
        end
        ST_PICK: begin
          if (any) begin
            cur       <= field_e'(idx);
            pend[idx] <= 1'b0;
            st        <= ST_W0;
          end else begin
            st <= ST_FIN;
          end
        end
        ST_W0: if (word_vld) begin
          ptr <= ptr + AW'(2);
          if (is_single(cur)) begin
            wr_en    <= 1'b1;
            wr_field <= cur;
            wr_hi    <= '0;
            wr_lo    <= word;
            st       <= ST_PICK;
          end else begin
            hi_q <= word;
            st   <= ST_W1;
          end
        end
        ST_W1: if (word_vld) begin
          ptr      <= ptr + AW'(2);
          wr_en    <= 1'b1;
          wr_field <= cur;
          wr_hi    <= hi_masked;
          wr_lo    <= word;
          if (cur == FLD_CHAIN) ca_loaded <= 1'b1;
          if (cur == FLD_MODE) begin
            cm_loaded <= 1'b1;
            cm_sr     <= hi_masked[SR_BIT];
          end
          st <= ST_PICK;
        end
        ST_FIN: begin
          if (!ca_loaded) begin
            wr_en    <= 1'b1;
            wr_field <= FLD_CHAIN;
            wr_hi    <= {ptr[AW-1:DW], ctl};
            wr_lo    <= ptr[DW-1:0];
          end
          done  <= 1'b1;
          sr_go <= cm_loaded ? cm_sr : cur_sr;
          busy  <= 1'b0;
          st    <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  logic [NFIELD-1:0] below_cur;
  always_comb begin
    below_cur = '0;
    for (int i = 0; i < NFIELD; i++) below_cur[i] = (i < int'(cur));
  end

  // R2: a field is fetched only after every lower-coded flag is consumed
  p_order_r2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_W0 && word_vld) |-> ((pend & below_cur) == '0));

  // R3: each completed word steps the pointer by one word
  p_ptr_step_r3: assert property (@(posedge clk) disable iff (rst)
    (word_vld && st != ST_IDLE) |=> (ptr == $past(ptr) + AW'(2)));

  // R6: done only when idle, and never twice in a row
  p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !$past(done)));

  // R6: writes happen only inside a load or with its done pulse
  p_wr_in_load_r6: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (busy || done));

  // R7: transfer launch only with completion
  p_sr_with_done_r7: assert property (@(posedge clk) disable iff (rst)
    sr_go |-> done);
endmodule

// File: tb/chain_loader_bench.sv
module chain_loader_bench;
  logic        clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst, start, cur_sr;
  logic [15:0] ca_hi, ca_lo;
  logic        busy, mem_req, wr_en, done, sr_go;
  logic [23:0] mem_addr;
  logic        mem_ack, resp_ack, spur_ack;
  logic [15:0] mem_rdata, wr_hi, wr_lo;
  logic [3:0]  wr_field;

  assign mem_ack = resp_ack | spur_ack;

  chain_loader u_chain_loader (
    .clk(clk), .rst(rst), .start(start), .ca_hi(ca_hi), .ca_lo(ca_lo),
    .cur_sr(cur_sr), .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .wr_en(wr_en),
    .wr_field(wr_field), .wr_hi(wr_hi), .wr_lo(wr_lo), .done(done),
    .sr_go(sr_go)
  );

  int tests = 0, fails = 0, cyc = 0;
  bit finished = 0;

  // bench memory image
  logic [23:0] hdr_addr;
  logic [15:0] hdr_word;
  function automatic logic [15:0] mem_fn(logic [23:0] a);
    if (a == hdr_addr) return hdr_word;
    return 16'((a[15:0] * 16'h9E37) ^ {a[23:16], 8'h5A});
  endfunction

  // expectations
  logic [3:0]  exp_f  [0:10];
  logic [15:0] exp_hi [0:10];
  logic [15:0] exp_lo [0:10];
  bit          exp_fb [0:10];
  int          exp_n, wi, rd_cnt, exp_rd, delay_cfg;
  logic [23:0] exp_addr_nxt;
  bit          exp_sr, done_seen, prev_done;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) cyc++;

  // memory responder
  bit in_txn = 0;
  int wait_left = 0;
  always @(negedge clk) begin
    if (rst) begin
      resp_ack = 0; in_txn = 0;
    end else if (resp_ack) begin
      resp_ack = 0; in_txn = 0;
    end else if (mem_req) begin
      if (!in_txn) begin
        in_txn = 1;
        wait_left = delay_cfg;
        chk(mem_addr == exp_addr_nxt, "R3 read address", 32'(mem_addr), 32'(exp_addr_nxt));
        exp_addr_nxt = exp_addr_nxt + 24'd2;
        rd_cnt++;
      end
      if (wait_left == 0) begin
        resp_ack = 1;
        mem_rdata = mem_fn(mem_addr);
      end else begin
        wait_left--;
      end
    end
  end

  // write and completion monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (wr_en) begin
        if (wi < exp_n) begin
          chk(wr_field == exp_f[wi], "R2 field order", 32'(wr_field), 32'(exp_f[wi]));
          chk(wr_hi == exp_hi[wi], exp_fb[wi] ? "R5 fallback upper" : "R4 upper word",
              32'(wr_hi), 32'(exp_hi[wi]));
          chk(wr_lo == exp_lo[wi], exp_fb[wi] ? "R5 fallback lower" : "R4 lower word",
              32'(wr_lo), 32'(exp_lo[wi]));
        end else begin
          chk(0, "R6 unexpected write", 32'(wr_field), 32'hFFFF);
        end
        wi++;
      end
      if (done) begin
        chk(wi == exp_n, "R2 write count", 32'(wi), 32'(exp_n));
        chk(rd_cnt == exp_rd, "R3 read count", 32'(rd_cnt), 32'(exp_rd));
        chk(!busy, "R6 busy low at done", 32'(busy), 0);
        chk(!prev_done, "R6 single-cycle done", 32'(prev_done), 0);
        chk(sr_go == exp_sr, "R7 software request", 32'(sr_go), 32'(exp_sr));
        done_seen = 1;
      end else begin
        chk(!sr_go || done, "R7 sr_go without done", 32'(sr_go), 0);
      end
      prev_done = done;
    end
  end

  task automatic run_load(logic [9:0] flags, logic [5:0] junk, logic [23:0] base,
                          logic [7:0] ctl, int dly, bit srv, bit restart);
    logic [23:0] a;
    logic [15:0] h, l;
    int n;
    bit cm_ld;
    logic [15:0] cm_hi;
    hdr_addr = base;
    hdr_word = {junk, flags};
    a = base + 24'd2;
    n = 0; exp_rd = 1; cm_ld = 0; cm_hi = 0;
    for (int f = 0; f < 10; f++) begin
      if (flags[9-f]) begin
        if (f == 2 || f == 5 || f == 7) begin
          h = 16'h0; l = mem_fn(a); a = a + 24'd2; exp_rd += 1;
        end else begin
          h = mem_fn(a); l = mem_fn(a + 24'd2); a = a + 24'd4; exp_rd += 2;
          if (f == 0 || f == 1 || f == 3 || f == 4) h = h & 16'hFFFE;
          else if (f == 8) begin h = h & 16'h001F; cm_ld = 1; cm_hi = h; end
          else if (f == 9) h = h & 16'hFF06;
        end
        exp_f[n] = 4'(f); exp_hi[n] = h; exp_lo[n] = l; exp_fb[n] = 0; n++;
      end
    end
    if (!flags[0]) begin
      exp_f[n] = 4'd9; exp_hi[n] = {a[23:16], ctl}; exp_lo[n] = a[15:0]; exp_fb[n] = 1; n++;
    end
    exp_n = n;
    exp_sr = cm_ld ? cm_hi[4] : srv;
    exp_addr_nxt = base;
    rd_cnt = 0; wi = 0; done_seen = 0; delay_cfg = dly;
    @(negedge clk);
    start = 1; ca_hi = {base[23:16], ctl}; ca_lo = base[15:0]; cur_sr = srv;
    @(negedge clk);
    start = 0;
    chk(busy == 1, "R1 busy after start", 32'(busy), 1);
    if (restart) begin
      @(negedge clk);
      start = 1; ca_hi = ~ca_hi; ca_lo = ~ca_lo;   // R1: must be ignored
      @(negedge clk);
      start = 0;
    end
    for (int g = 0; g < 3000 && !done_seen; g++) @(negedge clk);
    chk(done_seen, "R6 load completes", 32'(done_seen), 1);
    @(negedge clk);
  endtask

  initial begin
    rst = 1; start = 0; ca_hi = 0; ca_lo = 0; cur_sr = 0; spur_ack = 0;
    mem_rdata = 0; resp_ack = 0; hdr_addr = 24'hFFFFFF; hdr_word = 0;
    exp_n = 0; wi = 0; rd_cnt = 0; exp_rd = 0; delay_cfg = 0;
    exp_addr_nxt = 0; exp_sr = 0; done_seen = 0; prev_done = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // reset state
    chk(!busy && !mem_req && !wr_en && !done && !sr_go, "R1 reset state",
        {27'd0, busy, mem_req, wr_en, done, sr_go}, 0);

    // R8: stray acknowledge while idle has no effect
    spur_ack = 1;
    repeat (2) @(negedge clk);
    spur_ack = 0;
    @(negedge clk);
    chk(!busy && !mem_req && rd_cnt == 0 && wi == 0, "R8 stray ack ignored",
        {29'd0, busy, mem_req, wr_en}, 0);

    // sweep every reload-word flag pattern
    for (int t = 0; t < 1024; t++) begin
      logic [23:0] base;
      case (t % 4)
        0: base = 24'hFFFFE8;                       // wraps past 24 bits
        1: base = 24'h12FFF4;                       // crosses a 64 KiB boundary
        2: base = {8'(t), 16'h0100};
        default: base = 24'h400000 + 24'(t * 4);
      endcase
      run_load(10'(t), 6'(t) ^ 6'h2A, base, 8'(t) ^ 8'hC3, t % 3,
               t[4] ^ t[7], (t % 5) == 0);
    end

    // R8: stray acknowledge after loads still ignored
    spur_ack = 1;
    @(negedge clk);
    spur_ack = 0;
    @(negedge clk);
    chk(!busy && !mem_req, "R8 stray ack after loads", {30'd0, busy, mem_req}, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 190000 && !finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected<190000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule